// File: doc/BRIEF.md
# Interrupt and Trap Entry Sequencer

This block sits beside a processor's fetch logic and decides, each time an instruction completes, whether the next fetch continues normally or jumps into the kernel. It holds one pending flag per device, raised by that device's controller together with an identifying code. It also watches an error input, an external-signal input and the trap (service request) instruction strobe with its request number.

When it diverts, everything happens on one clock edge. The return PC and the current privilege mode are saved. The core goes to privileged mode with interrupts and memory protection switched off. A new PC is issued: either the single general handler address or a trap-table entry. Software fills the 16-entry trap table through a write port.

A return strobe undoes the entry on one edge. It reloads the saved PC, drops to user mode, and turns interrupts and protection back on, so a pending device can be taken at the very next boundary.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, priv_o=1, irq_en_o=0, mprot_en_o=0, pc_load_o=0 and dev_pend_o=0.
- R2: dev_set_i[i] sets device flag i and latches that device's code from dev_code_i. The flag stays set until dev_clr_i[i] clears it. If set and clear arrive in the same cycle, the flag stays set. Entry never clears a flag. dev_pend_o shows the flags.
- R3: Entry is considered only in cycles where boundary_i=1. With boundary_i=0, pc_load_o stays 0 unless a return was requested.
- R4: With irq_en_o=0, device flags and ext_irq_i cause no entry, and irq_en_o stays 0.
- R5: On the edge that takes an entry, the block does all of the following together. pc_load_o pulses high for one cycle. priv_o goes to 1 and irq_en_o and mprot_en_o go to 0. saved_pc_o takes next_pc_i. saved_priv_o takes the privilege level from before the entry.
- R6: A trap entry loads pc_o with trap-table entry trap_num_i. It reports cause type 2'b10 with trap_num_i as the cause code.
- R7: Error, external and device entries load pc_o with the HANDLER_PC parameter.
- R8: Cause types are encoded as 2'b00 device I/O, 2'b01 error and 2'b11 external. The code is the winning device's latched code for I/O entries, and 0 for error and external entries.
- R9: When several sources are pending, priority runs error, then trap, then external, then devices. Among devices, the lowest index wins.
- R10: Error and trap entries are taken even when irq_en_o=0.
- R11: On rti_i, the next cycle shows pc_load_o=1, pc_o equal to saved_pc_o, priv_o=0, irq_en_o=1 and mprot_en_o=1. If rti_i and boundary_i are high together, the return wins and no entry is taken.
- R12: After a return, the next boundary may take a pending device entry.
- R13: tbl_we_i writes tbl_data_i into entry tbl_idx_i, and a trap on a later cycle uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Current instruction completed; entry may be taken |
| next_pc_i | input | PC_W | PC that would be fetched next (return address) |
| dev_set_i | input | NDEV | Per-device flag set from controllers |
| dev_code_i | input | NDEV*CODE_W | Per-device identifying codes |
| dev_clr_i | input | NDEV | Software flag clear |
| trap_i | input | 1 | Trap instruction at this boundary |
| trap_num_i | input | log2(TBL_N) | Trap request number |
| err_i | input | 1 | Error condition at this boundary |
| ext_irq_i | input | 1 | External signal interrupt |
| rti_i | input | 1 | Return to user |
| tbl_we_i | input | 1 | Trap table write enable |
| tbl_idx_i | input | log2(TBL_N) | Trap table write index |
| tbl_data_i | input | PC_W | Trap table write data |
| pc_load_o | output | 1 | One-cycle PC redirect strobe |
| pc_o | output | PC_W | Redirect PC |
| priv_o | output | 1 | 1 = privileged mode |
| irq_en_o | output | 1 | Interrupt enable |
| mprot_en_o | output | 1 | Memory protection enable |
| cause_type_o | output | 2 | Cause type of last entry |
| cause_code_o | output | CODE_W | Cause code of last entry |
| saved_pc_o | output | PC_W | Saved return PC |
| saved_priv_o | output | 1 | Saved privilege level |
| dev_pend_o | output | NDEV | Device flags |

## Verification
Two pairs of actions can land in the same cycle. The first pair is a device flag set and a software clear of that same flag; the bench raises both for one device and then checks that dev_pend_o still shows it. The second pair is a return and an instruction boundary while a device is pending. The bench expects the return to win on that edge: the saved PC is reloaded and no entry is taken. It then expects the device entry to be taken at the following boundary, with the general handler PC and that device's code.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    CAUSE_IO  = 2'b00,
    CAUSE_ERR = 2'b01,
    CAUSE_SVC = 2'b10,
    CAUSE_EXT = 2'b11
  } cause_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NDEV   = 4,
  parameter int CODE_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NDEV-1:0]        set_i,
  input  logic [NDEV-1:0]        clr_i,
  input  logic [NDEV*CODE_W-1:0] code_i,
  output logic [NDEV-1:0]        flag_o,
  output logic [NDEV*CODE_W-1:0] code_o
);
  logic [NDEV-1:0] flag_q;

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        code_q    <= '0;
      end else if (set_i[i]) begin  // set beats a simultaneous clear
        flag_q[i] <= 1'b1;
        code_q    <= code_i[i*CODE_W +: CODE_W];
      end else if (clr_i[i]) begin
        flag_q[i] <= 1'b0;
      end
    end

    assign code_o[i*CODE_W +: CODE_W] = code_q;

    a_r2_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    a_r2_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_seq_pkg::*;
#(
  parameter int NDEV   = 4,
  parameter int CODE_W = 8,
  parameter int TIDX_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ie_i,
  input  logic                   err_i,
  input  logic                   trap_i,
  input  logic [TIDX_W-1:0]      trap_num_i,
  input  logic                   ext_i,
  input  logic [NDEV-1:0]        flag_i,
  input  logic [NDEV*CODE_W-1:0] code_i,
  output logic                   take_o,
  output cause_t                 type_o,
  output logic [CODE_W-1:0]      code_o
);
  localparam int DEV_IW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int GW     = NDEV + 3;

  logic              dev_hit;
  logic [DEV_IW-1:0] dev_win;
  logic [GW-1:0]     grant;

  always_comb begin
    dev_hit = 1'b0;
    dev_win = '0;
    for (int i = NDEV - 1; i >= 0; i--) begin
      if (flag_i[i]) begin
        dev_hit = 1'b1;
        dev_win = DEV_IW'(i);
      end
    end
  end

  always_comb begin
    grant  = '0;
    type_o = CAUSE_IO;
    code_o = '0;
    if (err_i) begin
      grant[GW-1] = 1'b1;
      type_o      = CAUSE_ERR;
    end else if (trap_i) begin
      grant[GW-2] = 1'b1;
      type_o      = CAUSE_SVC;
      code_o      = CODE_W'(trap_num_i);
    end else if (ie_i && ext_i) begin
      grant[GW-3] = 1'b1;
      type_o      = CAUSE_EXT;
    end else if (ie_i && dev_hit) begin
      grant[dev_win] = 1'b1;
      type_o         = CAUSE_IO;
      code_o         = code_i[dev_win*CODE_W +: CODE_W];
    end
  end

  assign take_o = err_i | trap_i | (ie_i & (ext_i | dev_hit));

  a_r9_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r4_masked_no_dev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> (grant[NDEV:0] == '0));
endmodule

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [$clog2(ENTRIES)-1:0] widx_i,
  input  logic [PC_W-1:0]            wdata_i,
  input  logic [$clog2(ENTRIES)-1:0] ridx_i,
  output logic [PC_W-1:0]            rdata_o
);
  logic [PC_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ENTRIES; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];

  a_r13_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ridx_i == widx_i) |=> (ridx_i != $past(widx_i)) || (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          NDEV       = 4,
  parameter int          CODE_W     = 8,
  parameter int          PC_W       = 32,
  parameter int          TBL_N      = 16,
  parameter logic [31:0] HANDLER_PC = 32'h0000_0100
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       boundary_i,
  input  logic [PC_W-1:0]            next_pc_i,
  input  logic [NDEV-1:0]            dev_set_i,
  input  logic [NDEV*CODE_W-1:0]     dev_code_i,
  input  logic [NDEV-1:0]            dev_clr_i,
  input  logic                       trap_i,
  input  logic [$clog2(TBL_N)-1:0]   trap_num_i,
  input  logic                       err_i,
  input  logic                       ext_irq_i,
  input  logic                       rti_i,
  input  logic                       tbl_we_i,
  input  logic [$clog2(TBL_N)-1:0]   tbl_idx_i,
  input  logic [PC_W-1:0]            tbl_data_i,
  output logic                       pc_load_o,
  output logic [PC_W-1:0]            pc_o,
  output logic                       priv_o,
  output logic                       irq_en_o,
  output logic                       mprot_en_o,
  output logic [1:0]                 cause_type_o,
  output logic [CODE_W-1:0]          cause_code_o,
  output logic [PC_W-1:0]            saved_pc_o,
  output logic                       saved_priv_o,
  output logic [NDEV-1:0]            dev_pend_o
);
  localparam int TIDX_W = $clog2(TBL_N);

  logic [NDEV-1:0]        flags;
  logic [NDEV*CODE_W-1:0] codes;
  logic                   take;
  cause_t                 sel_type;
  logic [CODE_W-1:0]      sel_code;
  logic [PC_W-1:0]        tbl_rdata;
  logic                   entry;

  logic              priv_q, ie_q, mprot_q, saved_priv_q, load_q;
  logic [PC_W-1:0]   pc_q, saved_pc_q;
  cause_t            cause_type_q;
  logic [CODE_W-1:0] cause_code_q;

  irq_flag_bank #(.NDEV(NDEV), .CODE_W(CODE_W)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dev_set_i),
    .clr_i  (dev_clr_i),
    .code_i (dev_code_i),
    .flag_o (flags),
    .code_o (codes)
  );

  irq_pick #(.NDEV(NDEV), .CODE_W(CODE_W), .TIDX_W(TIDX_W)) u_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ie_i       (ie_q),
    .err_i      (err_i),
    .trap_i     (trap_i),
    .trap_num_i (trap_num_i),
    .ext_i      (ext_irq_i),
    .flag_i     (flags),
    .code_i     (codes),
    .take_o     (take),
    .type_o     (sel_type),
    .code_o     (sel_code)
  );

  trap_vec_table #(.ENTRIES(TBL_N), .PC_W(PC_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .widx_i  (tbl_idx_i),
    .wdata_i (tbl_data_i),
    .ridx_i  (trap_num_i),
    .rdata_o (tbl_rdata)
  );

  // return wins over a coincident boundary
  assign entry = boundary_i & ~rti_i & take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q       <= 1'b1;
      ie_q         <= 1'b0;
      mprot_q      <= 1'b0;
      saved_priv_q <= 1'b0;
      saved_pc_q   <= '0;
      pc_q         <= '0;
      load_q       <= 1'b0;
      cause_type_q <= CAUSE_IO;
      cause_code_q <= '0;
    end else begin
      load_q <= entry | rti_i;
      if (rti_i) begin
        pc_q    <= saved_pc_q;
        priv_q  <= 1'b0;
        ie_q    <= 1'b1;
        mprot_q <= 1'b1;
      end else if (entry) begin
        saved_pc_q   <= next_pc_i;
        saved_priv_q <= priv_q;
        priv_q       <= 1'b1;
        ie_q         <= 1'b0;
        mprot_q      <= 1'b0;
        cause_type_q <= sel_type;
        cause_code_q <= sel_code;
        pc_q         <= (sel_type == CAUSE_SVC) ? tbl_rdata : PC_W'(HANDLER_PC);
      end
    end
  end

  assign pc_load_o    = load_q;
  assign pc_o         = pc_q;
  assign priv_o       = priv_q;
  assign irq_en_o     = ie_q;
  assign mprot_en_o   = mprot_q;
  assign cause_type_o = cause_type_q;
  assign cause_code_o = cause_code_q;
  assign saved_pc_o   = saved_pc_q;
  assign saved_priv_o = saved_priv_q;
  assign dev_pend_o   = flags;

  a_r5_entry_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (pc_load_o && priv_o && !irq_en_o && !mprot_en_o));
  a_r5_saved_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (saved_priv_o == $past(priv_o)) && (saved_pc_o == $past(next_pc_i)));
  a_r11_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_i |=> (pc_load_o && !priv_o && irq_en_o && mprot_en_o && pc_o == $past(saved_pc_o)));
  a_r3_no_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boundary_i && !rti_i) |=> !pc_load_o);
  a_r4_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !rti_i && !irq_en_o && !err_i && !trap_i) |=> (!pc_load_o && !irq_en_o));
endmodule

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
  localparam int          CLK_P   = 10;
  localparam logic [31:0] HANDLER = 32'h0000_0100;

  typedef struct packed {
    logic       ie;
    logic       err;
    logic       trap;
    logic [3:0] tnum;
    logic       ext;
    logic [3:0] devs;
    logic       load;
    logic [1:0] typ;
    logic [7:0] code;
    logic       tbl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'b0100, 1'b1, 2'b00, 8'hA2, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'b0110, 1'b1, 2'b00, 8'hA1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 4'b0001, 1'b1, 2'b11, 8'h00, 1'b0},
    '{1'b1, 1'b0, 1'b1, 4'd5,  1'b1, 4'b0001, 1'b1, 2'b10, 8'h05, 1'b1},
    '{1'b1, 1'b1, 1'b1, 4'd3,  1'b0, 4'b0000, 1'b1, 2'b01, 8'h00, 1'b0},
    '{1'b0, 1'b0, 1'b0, 4'd0,  1'b1, 4'b1000, 1'b0, 2'b00, 8'h00, 1'b0},
    '{1'b0, 1'b0, 1'b1, 4'd15, 1'b0, 4'b0000, 1'b1, 2'b10, 8'h0F, 1'b1},
    '{1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 4'b0000, 1'b1, 2'b01, 8'h00, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  1'b0, 4'b0000, 1'b0, 2'b00, 8'h00, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boundary_i = 1'b0;
  logic [31:0] next_pc_i = '0;
  logic [3:0]  dev_set_i = '0;
  logic [31:0] dev_code_i = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
  logic [3:0]  dev_clr_i = '0;
  logic        trap_i = 1'b0;
  logic [3:0]  trap_num_i = '0;
  logic        err_i = 1'b0;
  logic        ext_irq_i = 1'b0;
  logic        rti_i = 1'b0;
  logic        tbl_we_i = 1'b0;
  logic [3:0]  tbl_idx_i = '0;
  logic [31:0] tbl_data_i = '0;
  logic        pc_load_o, priv_o, irq_en_o, mprot_en_o, saved_priv_o;
  logic [31:0] pc_o, saved_pc_o;
  logic [1:0]  cause_type_o;
  logic [7:0]  cause_code_o;
  logic [3:0]  dev_pend_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  trap_entry_seq u_trap_entry_seq (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary_i), .next_pc_i(next_pc_i),
    .dev_set_i(dev_set_i), .dev_code_i(dev_code_i), .dev_clr_i(dev_clr_i),
    .trap_i(trap_i), .trap_num_i(trap_num_i), .err_i(err_i), .ext_irq_i(ext_irq_i),
    .rti_i(rti_i), .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_data_i(tbl_data_i),
    .pc_load_o(pc_load_o), .pc_o(pc_o), .priv_o(priv_o), .irq_en_o(irq_en_o),
    .mprot_en_o(mprot_en_o), .cause_type_o(cause_type_o), .cause_code_o(cause_code_o),
    .saved_pc_o(saved_pc_o), .saved_priv_o(saved_priv_o), .dev_pend_o(dev_pend_o)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] tbl_val(int k);
    return 32'h2000 + 32'(k) * 32'h40;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic pre_priv;
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 priv", 32'(priv_o), 1);
    check("R1 ie", 32'(irq_en_o), 0);
    check("R1 mprot", 32'(mprot_en_o), 0);
    check("R1 load", 32'(pc_load_o), 0);
    check("R1 pend", 32'(dev_pend_o), 0);

    for (int k = 0; k < 16; k++) begin
      tbl_we_i = 1'b1; tbl_idx_i = 4'(k); tbl_data_i = tbl_val(k);
      tick();
    end
    tbl_we_i = 1'b0;

    for (int v = 0; v < NV; v++) begin
      dev_clr_i = '1; tick(); dev_clr_i = '0;
      if (VECS[v].ie) begin
        rti_i = 1'b1; tick(); rti_i = 1'b0;
      end
      if (VECS[v].devs != 0) begin
        dev_set_i = VECS[v].devs; tick(); dev_set_i = '0;
      end
      next_pc_i  = 32'h4000 + 32'(v) * 4;
      err_i      = VECS[v].err;
      trap_i     = VECS[v].trap;
      trap_num_i = VECS[v].tnum;
      ext_irq_i  = VECS[v].ext;
      boundary_i = 1'b1;
      pre_priv   = priv_o;
      tick();
      boundary_i = 1'b0; err_i = 1'b0; trap_i = 1'b0; ext_irq_i = 1'b0;
      check(VECS[v].ie ? "R5/R9 load" : "R4/R10 load", 32'(pc_load_o), 32'(VECS[v].load));
      if (VECS[v].load) begin
        check(VECS[v].tbl ? "R6 pc" : "R7 pc", pc_o,
              VECS[v].tbl ? tbl_val(int'(VECS[v].tnum)) : HANDLER);
        check("R8/R9 type", 32'(cause_type_o), 32'(VECS[v].typ));
        check("R8/R6 code", 32'(cause_code_o), 32'(VECS[v].code));
        check("R5 priv", 32'(priv_o), 1);
        check("R5 ie", 32'(irq_en_o), 0);
        check("R5 mprot", 32'(mprot_en_o), 0);
        check("R5 saved pc", saved_pc_o, next_pc_i);
        check("R5 saved priv", 32'(saved_priv_o), 32'(pre_priv));
        check("R2 flags kept", 32'(dev_pend_o), 32'(VECS[v].devs));
      end else begin
        check("R4 ie unchanged", 32'(irq_en_o), 32'(VECS[v].ie));
      end
      tick();
      check("R5 single pulse", 32'(pc_load_o), 0);
    end

    // R3: pending device, ie=1, no boundary
    dev_set_i = 4'b0001; tick(); dev_set_i = '0;
    for (int c = 0; c < 3; c++) begin
      tick();
      check("R3 no boundary", 32'(pc_load_o), 0);
    end
    // R2: set and clear together, then clear alone
    dev_set_i = 4'b0010; dev_clr_i = 4'b0010; tick();
    dev_set_i = '0; dev_clr_i = '0;
    check("R2 set wins", 32'(dev_pend_o[1]), 1);
    dev_clr_i = '1; tick(); dev_clr_i = '0;
    check("R2 cleared", 32'(dev_pend_o), 0);

    // R11: entry, then return coincident with boundary while device pending
    dev_set_i = 4'b0100; tick(); dev_set_i = '0;
    next_pc_i = 32'h5550; boundary_i = 1'b1; tick(); boundary_i = 1'b0;
    check("R11 setup entry", 32'(pc_load_o), 1);
    rti_i = 1'b1; boundary_i = 1'b1; next_pc_i = 32'h5554; tick();
    rti_i = 1'b0; boundary_i = 1'b0;
    check("R11 load", 32'(pc_load_o), 1);
    check("R11 pc", pc_o, 32'h5550);
    check("R11 priv", 32'(priv_o), 0);
    check("R11 ie", 32'(irq_en_o), 1);
    check("R11 mprot", 32'(mprot_en_o), 1);
    check("R11 no entry saved pc", saved_pc_o, 32'h5550);
    // R12: next boundary takes the still-pending device
    next_pc_i = 32'h6000; boundary_i = 1'b1; tick(); boundary_i = 1'b0;
    check("R12 load", 32'(pc_load_o), 1);
    check("R12 pc", pc_o, HANDLER);
    check("R12 code", 32'(cause_code_o), 32'hA2);
    check("R12 priv", 32'(priv_o), 1);

    // R13: rewrite an entry, then trap on it
    tbl_we_i = 1'b1; tbl_idx_i = 4'd7; tbl_data_i = 32'h000B_EEF0; tick();
    tbl_we_i = 1'b0;
    trap_i = 1'b1; trap_num_i = 4'd7; boundary_i = 1'b1; tick();
    trap_i = 1'b0; boundary_i = 1'b0;
    check("R13 load", 32'(pc_load_o), 1);
    check("R13 pc", pc_o, 32'h000B_EEF0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule